// File: doc/BRIEF.md
# Hysteresis Threshold Gate Bank

This block models a family of m-of-n threshold gates with hysteresis, the basic storage-bearing element of four-phase dual-rail asynchronous logic. Each gate watches its own set of n input rails. Its output goes high once at least m of those rails are high. After that it stays high until every one of its rails has gone low again. For any input pattern between those two conditions, the gate keeps its last output value.

Each gate is built from a set term, a hold term and a reset term. A control part derives these terms from the rails, and a state part holds the output through feedback, together with its complement. For simulation and cycle-level modelling the feedback is evaluated on each rising clock edge. An active-high asynchronous reset puts every gate into the NULL state (output low).

The bank instantiates every gate with a threshold m from 1 to n, for every input count n from 2 to `MAX_N`. The gate with n inputs reads the lowest n rails. Its output index is base(n) + m - 1, where base(2) = 0 and base(n+1) = base(n) + n. With `MAX_N` = 4 this gives nine gates, (1,2) through (4,4). A threshold or input count outside 1 ≤ m ≤ n ≤ 4 stops elaboration.

Top module: `thGateBank`

## Requirements
- R1: While `rst` is high, and until the first rising edge after it falls, every bit of `gateOut` is 0 and every bit of `gateOutN` is 1.
- R2: If, at a rising edge, at least m of the rails `rails[n-1:0]` are high, the output of gate (m,n) is 1 after that edge.
- R3: If gate (m,n) is high and at least one of its rails is high at a rising edge, it stays high after that edge, even when fewer than m rails are high.
- R4: If all rails of gate (m,n) are low at a rising edge, its output is 0 after that edge.
- R5: If gate (m,n) is low and fewer than m of its rails are high at a rising edge, it stays low after that edge.
- R6: Each bit of `gateOutN` is the complement of the same bit of `gateOut` at all times outside reset.
- R7: Gate (m,n) sits at bit base(n)+m-1 of `gateOut`, and it depends only on `rails[n-1:0]`. Rails at index n or above have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock for the feedback state |
| rst | input | 1 | Active-high asynchronous reset to NULL |
| rails | input | MAX_N | Input rails; gate n reads bits n-1..0 |
| gateOut | output | GATE_CNT | True output of every gate |
| gateOutN | output | GATE_CNT | Complemented output of every gate |

## Verification
Every gate result is due one rising edge after its rails are presented. Nothing else lies on the path, so the expected value for that edge follows from the rails sampled there and from the reference state held from the previous edge. The bench changes the rails just after a falling edge. It compares all gates, and both output rails of each, 1 ns after the next rising edge. At that moment the outputs already reflect that edge and nothing else has moved yet. The reference model keeps its own state per gate and is updated at the same edge.

// File: rtl/thGatePkg.sv
package thGatePkg;

  typedef struct packed {
    logic setHit;    // at least M rails high
    logic holdAny;   // any rail high
    logic resetHit;  // every rail low
  } thStrobes_t;

  // First output index of the gate family with n inputs
  function automatic int gateBase(input int n);
    return ((n - 1) * n) / 2 - 1;
  endfunction

  // Total gates for input counts 2..maxN
  function automatic int gateCount(input int maxN);
    return gateBase(maxN + 1);
  endfunction

endpackage

// File: rtl/thGateCtrl.sv
module thGateCtrl
  import thGatePkg::*;
#(
  parameter int M = 2,
  parameter int N = 3
) (
  input  logic [N-1:0] inRails,
  output thStrobes_t   strobes
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] highCnt;

  always_comb begin
    highCnt = '0;
    for (int i = 0; i < N; i++) begin
      highCnt = highCnt + CW'(inRails[i]);
    end
  end

  always_comb begin
    strobes.setHit   = (highCnt >= CW'(M));
    strobes.holdAny  = |inRails;
    strobes.resetHit = ~(|inRails);
  end
endmodule

// File: rtl/thGateHold.sv
module thGateHold
  import thGatePkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  thStrobes_t strobes,
  output logic       q,
  output logic       qBar
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q    <= 1'b0;
      qBar <= 1'b1;
    end else begin
      q    <= strobes.setHit | (q & strobes.holdAny);
      qBar <= strobes.resetHit | (qBar & ~strobes.setHit);
    end
  end
endmodule

// File: rtl/thGate.sv
module thGate
  import thGatePkg::*;
#(
  parameter int M = 2,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] inRails,
  output logic         q,
  output logic         qBar
);
  generate
    if (M < 1 || M > N || N > 4) begin : g_badParams
      $error("thGate: threshold/input count out of range");
    end
  endgenerate

  thStrobes_t strobes;

  thGateCtrl #(.M(M), .N(N)) ctrl_i (
    .inRails (inRails),
    .strobes (strobes)
  );

  thGateHold hold_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .q       (q),
    .qBar    (qBar)
  );
endmodule

// File: rtl/thGateBank.sv
module thGateBank
  import thGatePkg::*;
#(
  parameter int MAX_N    = 4,
  localparam int GATE_CNT = gateCount(MAX_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [MAX_N-1:0]    rails,
  output logic [GATE_CNT-1:0] gateOut,
  output logic [GATE_CNT-1:0] gateOutN
);
  generate
    if (MAX_N < 2 || MAX_N > 4) begin : g_badMax
      $error("thGateBank: MAX_N must be 2..4");
    end
    for (genvar n = 2; n <= MAX_N; n++) begin : g_n
      for (genvar m = 1; m <= n; m++) begin : g_m
        localparam int IDX = gateBase(n) + m - 1;
        thGate #(.M(m), .N(n)) gate_i (
          .clk     (clk),
          .rst     (rst),
          .inRails (rails[n-1:0]),
          .q       (gateOut[IDX]),
          .qBar    (gateOutN[IDX])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/thGateBankChk.sv
module thGateBankChk
  import thGatePkg::*;
#(
  parameter int MAX_N    = 4,
  localparam int GATE_CNT = gateCount(MAX_N)
) (
  input logic                clk,
  input logic                rst,
  input logic [MAX_N-1:0]    rails,
  input logic [GATE_CNT-1:0] gateOut,
  input logic [GATE_CNT-1:0] gateOutN
);
  // R1: reset forces NULL on every gate
  a_r1_reset_null: assert property (@(posedge clk)
    rst |=> (gateOut == '0 && gateOutN == '1));

  generate
    for (genvar n = 2; n <= MAX_N; n++) begin : g_n
      for (genvar m = 1; m <= n; m++) begin : g_m
        localparam int IDX = gateBase(n) + m - 1;

        // R6
        a_r6_complement: assert property (@(posedge clk) disable iff (rst)
          gateOut[IDX] != gateOutN[IDX]);

        // R2
        a_r2_set: assert property (@(posedge clk) disable iff (rst)
          ($countones(rails[n-1:0]) >= m) |=> gateOut[IDX]);

        // R3
        a_r3_hold_high: assert property (@(posedge clk) disable iff (rst)
          (gateOut[IDX] && rails[n-1:0] != '0) |=> gateOut[IDX]);

        // R4
        a_r4_release: assert property (@(posedge clk) disable iff (rst)
          (rails[n-1:0] == '0) |=> !gateOut[IDX]);

        // R5
        a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
          (!gateOut[IDX] && $countones(rails[n-1:0]) < m) |=> !gateOut[IDX]);
      end
    end
  endgenerate
endmodule

bind thGateBank thGateBankChk #(.MAX_N(MAX_N)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rails    (rails),
  .gateOut  (gateOut),
  .gateOutN (gateOutN)
);

// File: tb/thGateBank_tb_top.sv
`timescale 1ns/1ps
module thGateBank_tb_top;
  import thGatePkg::*;

  localparam int MAX_N    = 4;
  localparam int GATE_CNT = gateCount(MAX_N);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [MAX_N-1:0]    rails = '0;
  logic [GATE_CNT-1:0] gateOut;
  logic [GATE_CNT-1:0] gateOutN;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  bit  refQ [GATE_CNT];

  always #2.5 clk = ~clk;

  thGateBank #(.MAX_N(MAX_N)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .rails    (rails),
    .gateOut  (gateOut),
    .gateOutN (gateOutN)
  );

  function automatic int popLow(input logic [MAX_N-1:0] v, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic string tagFor(input bit prev, input int cnt, input int m);
    if (cnt >= m) return "R2";
    if (cnt == 0) return "R4";
    if (prev)     return "R3";
    return "R5";
  endfunction

  task automatic checkBit(input string req, input int idx, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s gate=%0d rails=%b actual=%b expected=%b", req, idx, rails, act, exp);
    end
  endtask

  // Present rails after a falling edge; check 1 ns after the next rising edge
  task automatic applyRails(input logic [MAX_N-1:0] v, input bit r7);
    string tags [GATE_CNT];
    @(negedge clk);
    rails = v;
    @(posedge clk);
    for (int n = 2; n <= MAX_N; n++) begin
      for (int m = 1; m <= n; m++) begin
        int idx = gateBase(n) + m - 1;
        int cnt = popLow(v, n);
        tags[idx] = r7 ? "R7" : tagFor(refQ[idx], cnt, m);
        refQ[idx] = (cnt >= m) || (refQ[idx] && cnt > 0);
      end
    end
    #1;
    for (int i = 0; i < GATE_CNT; i++) begin
      checkBit(tags[i], i, gateOut[i], refQ[i]);
      checkBit("R6", i, gateOutN[i], ~refQ[i]);
    end
  endtask

  // Four-phase style wave: raise rails in random order, then drop them
  task automatic wave();
    logic [MAX_N-1:0] v = '0;
    int target = int'($urandom_range(MAX_N, 1));
    for (int k = 0; k < target; k++) begin
      v[$urandom_range(MAX_N-1, 0)] = 1'b1;
      applyRails(v, 1'b0);
    end
    while (v != '0) begin
      v[$urandom_range(MAX_N-1, 0)] = 1'b0;
      applyRails(v, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < GATE_CNT; i++) refQ[i] = 1'b0;
    rails = '1;  // inputs high during reset must not leak through
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < GATE_CNT; i++) begin
      checkBit("R1", i, gateOut[i], 1'b0);
      checkBit("R1", i, gateOutN[i], 1'b1);
    end
    @(negedge clk);
    rails = '0;
    rst   = 1'b0;

    // Directed corners
    applyRails('0, 1'b0);
    applyRails(4'b1111, 1'b0);   // R2: every gate sets
    applyRails(4'b0001, 1'b0);   // R3: all held high on one rail
    applyRails(4'b0100, 1'b0);   // R3: gates n=2 released, R4
    applyRails(4'b0000, 1'b0);   // R4: all released
    applyRails(4'b1000, 1'b1);   // R7: only gate n=4 family sees it
    applyRails(4'b1100, 1'b1);   // R7
    applyRails(4'b1000, 1'b1);   // R7
    applyRails(4'b0000, 1'b0);
    applyRails(4'b0011, 1'b0);   // R2 for M<=2, R5 for higher
    applyRails(4'b0110, 1'b0);   // R5: no growth without threshold
    applyRails(4'b0000, 1'b0);

    for (int w = 0; w < 300; w++) wave();
    for (int k = 0; k < 500; k++) applyRails(MAX_N'($urandom), 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule